// File: doc/BRIEF.md
# Transmitter Protection Gate

This block stands between the transmit-data pin of a bus transceiver and the enable of its bus driver. It passes the dominant request from the pin to the driver, and it cuts the driver off under three conditions. The first is a transmit-data level held low for too long. The second is an overtemperature indication. The third is the standby mode. Neither fault needs software to recover. Both the stuck-low watchdog and the thermal shutdown latch are released only by the transmit-data pin returning high, so a controller that resumes normal signalling gets the bus back by itself.

The pin and the overtemperature flag come from outside the clock domain, so both pass through a configurable synchronizer before any decision is made. A pin that is not connected is modelled by a presence input. While that input is low, the block sees a recessive (high) level, the same as an internal pull-up would give. The time-out is a parameter in clock cycles. At elaboration it is checked against the longest legal dominant run at the slowest supported bit rate.

Top module: `txprot_gate`

## Requirements
- R1: While reset is held and right after it is released, `tx_en` is 1 (when not in standby) and `bus_dom` is 0. Reset clears the watchdog, the thermal latch and the synchronizer, which comes out of reset at the recessive level.
- R2: With no fault and not in standby, `bus_dom` is the inverse of `txd_pin` (pin 0 = dominant request), delayed by SYNC_STAGES clock edges.
- R3: If `txd_pin` stays 0 continuously, `tx_en` and `bus_dom` go to 0 exactly TIMEOUT_CYC+SYNC_STAGES clock edges after the pin falls, and not one edge earlier. No uninterrupted `bus_dom` run is longer than TIMEOUT_CYC cycles.
- R4: Once the time-out has fired, `txd_pin` staying 0 for any length of time keeps `tx_en` at 0.
- R5: A return of `txd_pin` to 1 releases the time-out, and `tx_en` is back at 1 SYNC_STAGES+1 edges after the rise. Each new low period restarts the count from zero, so repeated lows that are each shorter than the time-out never disable the driver.
- R6: `otemp_in` = 1 drives `tx_en` to 0 within SYNC_STAGES+1 edges, and this state stays latched after the flag clears. Holding the pin low does not release it, and neither does holding the pin high. Only a 0-to-1 transition of the pin releases it.
- R7: A rising edge of the pin that arrives while the synchronized `otemp_in` is still 1 does not release the thermal latch. A later rise with the flag clear does.
- R8: `standby_in` = 1 forces `tx_en` and `bus_dom` to 0 in the same cycle, with no clock edge needed. Returning to 0 restores them at once if no fault is latched.
- R9: While `txd_present` is 0, the pin is taken as 1 (recessive) whatever `txd_pin` shows. It never produces `bus_dom`, never runs the time-out, and it releases a fired time-out as a rising level would.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_pin | input | 1 | Transmit-data pin level, 0 = dominant request |
| txd_present | input | 1 | 1 when the pin is driven, 0 models a disconnected pin |
| otemp_in | input | 1 | Overtemperature indication, 1 = too hot |
| standby_in | input | 1 | Operating mode, 1 = standby, 0 = normal |
| tx_en | output | 1 | Bus driver enable |
| bus_dom | output | 1 | Gated dominant request to the driver |

## Verification
A wrong watchdog count shows at `tx_en` as a disable that comes one edge early or late. Such an error is only visible at the exact TIMEOUT_CYC+SYNC_STAGES boundary, so the bench samples just before and just after that edge. A watchdog or thermal latch that fails to stick, or that is released by the wrong event, shows as `tx_en` returning to 1 while the pin is still low. It can also show as `tx_en` returning while the overtemperature flag is still up, and this becomes visible within SYNC_STAGES+1 edges of the offending stimulus. A broken standby gate or presence default shows in the same cycle as a `bus_dom` pulse that should not be there.

// File: rtl/txprot_pkg.sv
package txprot_pkg;

   // operating mode as seen on standby_in
   typedef enum logic {
      MODE_NORMAL  = 1'b0,
      MODE_STANDBY = 1'b1
   } txprot_mode_e;

   // bundle of asynchronous inputs passed through the synchronizer
   typedef struct packed {
      logic txd;   // 1 = recessive
      logic hot;   // 1 = overtemperature
   } txprot_in_t;

   localparam int unsigned IN_W = $bits(txprot_in_t);

   // synchronizer leaves reset at recessive, not hot
   localparam txprot_in_t IN_RST = '{txd: 1'b1, hot: 1'b0};

endpackage

// File: rtl/txprot_sync.sv
module txprot_sync #(
   parameter int unsigned             W       = 2,
   parameter int unsigned             STAGES  = 2,
   parameter logic        [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W == 0) begin : g_bad_w
      $error("txprot_sync: W must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r <= {STAGES{RST_VAL}};
         end else begin
            r[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
               r[i] <= r[i-1];
            end
         end
      end

      assign q = r[STAGES-1];
   end

endmodule

// File: rtl/txprot_dom_timer.sv
module txprot_dom_timer #(
   parameter int unsigned TIMEOUT_CYC = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic txd_s,     // synchronized level, 1 = recessive
   output logic to_flag,   // time-out has fired
   output logic txd_rise   // 0 -> 1 transition of txd_s this cycle
);

   localparam int unsigned CNT_W   = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

   logic [CNT_W-1:0] cnt;
   logic             txd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txd_q <= 1'b1;
      end else begin
         txd_q <= txd_s;
      end
   end

   assign txd_rise = txd_s & ~txd_q;

   // count only while low; any high level restarts and releases
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         to_flag <= 1'b0;
      end else if (txd_s) begin
         cnt     <= '0;
         to_flag <= 1'b0;
      end else if (!to_flag) begin
         if (cnt == CNT_LAST) begin
            to_flag <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/txprot_therm_latch.sv
module txprot_therm_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic hot_s,
   input  logic txd_rise,
   output logic th_flag
);

   // hot wins over a coincident rise, so a rise under heat is ignored
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         th_flag <= 1'b0;
      end else if (hot_s) begin
         th_flag <= 1'b1;
      end else if (txd_rise) begin
         th_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/txprot_gate.sv
module txprot_gate
   import txprot_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned SLOW_BIT_CYC = 4,   // clock cycles per bit at slowest rate
   parameter int unsigned MAX_DOM_BITS = 17,  // longest legal dominant run in bits
   parameter int unsigned TIMEOUT_CYC  = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic txd_pin,
   input  logic txd_present,
   input  logic otemp_in,
   input  logic standby_in,
   output logic tx_en,
   output logic bus_dom
);

   localparam int unsigned LEGAL_RUN_CYC = SLOW_BIT_CYC * MAX_DOM_BITS;

   if (TIMEOUT_CYC <= LEGAL_RUN_CYC) begin : g_bad_timeout
      $error("txprot_gate: TIMEOUT_CYC must exceed the longest legal dominant run");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_min
      $error("txprot_gate: TIMEOUT_CYC must be at least 2");
   end

   txprot_in_t   raw;
   txprot_in_t   syn;
   txprot_mode_e mode;
   logic         txd_s;
   logic         otemp_s;
   logic         to_flag;
   logic         th_flag;
   logic         txd_rise;

   // a missing pin reads as recessive
   assign raw.txd = txd_present ? txd_pin : 1'b1;
   assign raw.hot = otemp_in;

   txprot_sync #(
      .W       (IN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn)
   );

   assign txd_s   = syn.txd;
   assign otemp_s = syn.hot;

   txprot_dom_timer #(
      .TIMEOUT_CYC (TIMEOUT_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .txd_s    (txd_s),
      .to_flag  (to_flag),
      .txd_rise (txd_rise)
   );

   txprot_therm_latch u_therm (
      .clk      (clk),
      .rst_n    (rst_n),
      .hot_s    (otemp_s),
      .txd_rise (txd_rise),
      .th_flag  (th_flag)
   );

   assign mode    = txprot_mode_e'(standby_in);
   assign tx_en   = (mode == MODE_NORMAL) & ~to_flag & ~th_flag;
   assign bus_dom = tx_en & ~txd_s;

endmodule

// File: rtl/txprot_gate_chk.sv
module txprot_gate_chk #(
   parameter int unsigned TIMEOUT_CYC = 80
) (
   input logic clk,
   input logic rst_n,
   input logic standby_in,
   input logic tx_en,
   input logic bus_dom,
   input logic txd_s,
   input logic otemp_s,
   input logic to_flag,
   input logic th_flag
);

   localparam int unsigned RUN_W = $clog2(TIMEOUT_CYC + 2);

   logic [RUN_W-1:0] dom_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dom_run <= '0;
      end else if (bus_dom) begin
         if (dom_run != {RUN_W{1'b1}}) dom_run <= dom_run + 1'b1;
      end else begin
         dom_run <= '0;
      end
   end

   AST_STBY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      standby_in |-> (!tx_en && !bus_dom)); // R8

   AST_DOM_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dom |-> (dom_run < RUN_W'(TIMEOUT_CYC))); // R3

   AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (to_flag && !txd_s) |=> to_flag); // R4

   AST_TO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (to_flag && txd_s) |=> !to_flag); // R5

   AST_HOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      otemp_s |=> !tx_en); // R6

   AST_HOT_STICKY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (th_flag && !txd_s) |=> th_flag); // R6

   AST_HOT_RISE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (th_flag && otemp_s) |=> th_flag); // R7

endmodule

bind txprot_gate txprot_gate_chk #(
   .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .standby_in (standby_in),
   .tx_en      (tx_en),
   .bus_dom    (bus_dom),
   .txd_s      (txd_s),
   .otemp_s    (otemp_s),
   .to_flag    (to_flag),
   .th_flag    (th_flag)
);

// File: tb/txprot_gate_tb.sv
module txprot_gate_tb;

   localparam int unsigned SY = 2;
   localparam int unsigned TO = 80;
   localparam int unsigned NV = 32;

   typedef struct packed {
      logic        pres;
      logic        txd;
      logic        hot;
      logic        stby;
      logic [15:0] wt;     // rising edges to wait before sampling
      logic        en;
      logic        dom;
      logic [7:0]  req;
   } vec_t;

   localparam vec_t [0:NV-1] VEC = '{
      '{1'b1,1'b1,1'b0,1'b0, 16'd3,        1'b1,1'b0, 8'd1}, // R1 idle after reset
      '{1'b1,1'b0,1'b0,1'b0, 16'd1,        1'b1,1'b0, 8'd2}, // R2 one stage only
      '{1'b1,1'b0,1'b0,1'b0, 16'd1,        1'b1,1'b1, 8'd2}, // R2 dominant after 2 edges
      '{1'b1,1'b1,1'b0,1'b0, 16'd3,        1'b1,1'b0, 8'd2}, // R2 back to recessive
      '{1'b1,1'b0,1'b0,1'b0, 16'(TO+SY-1), 1'b1,1'b1, 8'd3}, // R3 one edge before limit
      '{1'b1,1'b0,1'b0,1'b0, 16'd1,        1'b0,1'b0, 8'd3}, // R3 limit edge
      '{1'b1,1'b0,1'b0,1'b0, 16'd100,      1'b0,1'b0, 8'd4}, // R4 stays off while low
      '{1'b1,1'b1,1'b0,1'b0, 16'(SY),      1'b0,1'b0, 8'd5}, // R5 not yet released
      '{1'b1,1'b1,1'b0,1'b0, 16'd1,        1'b1,1'b0, 8'd5}, // R5 released
      '{1'b1,1'b0,1'b0,1'b0, 16'(TO-10),   1'b1,1'b1, 8'd5}, // R5 short low 1
      '{1'b1,1'b1,1'b0,1'b0, 16'd3,        1'b1,1'b0, 8'd5}, // R5 gap
      '{1'b1,1'b0,1'b0,1'b0, 16'(TO-10),   1'b1,1'b1, 8'd5}, // R5 short low 2, count restarted
      '{1'b1,1'b1,1'b0,1'b0, 16'd3,        1'b1,1'b0, 8'd5}, // R5 gap
      '{1'b1,1'b1,1'b1,1'b0, 16'(SY),      1'b1,1'b0, 8'd6}, // R6 hot still in sync
      '{1'b1,1'b1,1'b1,1'b0, 16'd1,        1'b0,1'b0, 8'd6}, // R6 hot latched
      '{1'b1,1'b1,1'b0,1'b0, 16'd10,       1'b0,1'b0, 8'd6}, // R6 stays off, pin high
      '{1'b1,1'b0,1'b0,1'b0, 16'd3,        1'b0,1'b0, 8'd6}, // R6 low does not release
      '{1'b1,1'b1,1'b0,1'b0, 16'd3,        1'b1,1'b0, 8'd6}, // R6 rise releases
      '{1'b1,1'b0,1'b1,1'b0, 16'd5,        1'b0,1'b0, 8'd7}, // R7 hot while low
      '{1'b1,1'b1,1'b1,1'b0, 16'd5,        1'b0,1'b0, 8'd7}, // R7 rise under heat ignored
      '{1'b1,1'b1,1'b0,1'b0, 16'd5,        1'b0,1'b0, 8'd7}, // R7 cool but no new rise
      '{1'b1,1'b0,1'b0,1'b0, 16'd3,        1'b0,1'b0, 8'd7}, // R7 low
      '{1'b1,1'b1,1'b0,1'b0, 16'd3,        1'b1,1'b0, 8'd7}, // R7 later rise releases
      '{1'b1,1'b0,1'b0,1'b1, 16'd3,        1'b0,1'b0, 8'd8}, // R8 standby blocks
      '{1'b1,1'b0,1'b0,1'b0, 16'd0,        1'b1,1'b1, 8'd8}, // R8 leave standby at once
      '{1'b1,1'b1,1'b0,1'b0, 16'd3,        1'b1,1'b0, 8'd8}, // R8 recessive
      '{1'b0,1'b0,1'b0,1'b0, 16'd5,        1'b1,1'b0, 8'd9}, // R9 missing pin recessive
      '{1'b0,1'b0,1'b0,1'b0, 16'(TO+20),   1'b1,1'b0, 8'd9}, // R9 no time-out
      '{1'b1,1'b0,1'b0,1'b0, 16'd2,        1'b1,1'b1, 8'd9}, // R9 pin reconnected
      '{1'b1,1'b0,1'b0,1'b0, 16'(TO),      1'b0,1'b0, 8'd3}, // R3 fires again
      '{1'b0,1'b0,1'b0,1'b0, 16'd3,        1'b1,1'b0, 8'd9}, // R9 missing pin releases
      '{1'b1,1'b1,1'b0,1'b0, 16'd3,        1'b1,1'b0, 8'd9}  // R9 idle
   };

   logic clk = 1'b0;
   logic rst_n;
   logic txd_pin, txd_present, otemp_in, standby_in;
   logic tx_en, bus_dom;

   int n_run  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   txprot_gate #(
      .SYNC_STAGES (SY),
      .TIMEOUT_CYC (TO)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .txd_pin     (txd_pin),
      .txd_present (txd_present),
      .otemp_in    (otemp_in),
      .standby_in  (standby_in),
      .tx_en       (tx_en),
      .bus_dom     (bus_dom)
   );

   task automatic check(input logic exp_en, input logic exp_dom, input string tag);
      n_run++;
      if (tx_en !== exp_en || bus_dom !== exp_dom) begin
         n_fail++;
         $display("FAIL %s: tx_en=%b bus_dom=%b expected tx_en=%b bus_dom=%b",
                  tag, tx_en, bus_dom, exp_en, exp_dom);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      rst_n       = 1'b0;
      txd_pin     = 1'b1;
      txd_present = 1'b1;
      otemp_in    = 1'b0;
      standby_in  = 1'b0;
      edges(2);
      check(1'b1, 1'b0, "R1 during reset");
      rst_n = 1'b1;
      edges(1);
      check(1'b1, 1'b0, "R1 after release");

      for (int i = 0; i < NV; i++) begin
         txd_present = VEC[i].pres;
         txd_pin     = VEC[i].txd;
         otemp_in    = VEC[i].hot;
         standby_in  = VEC[i].stby;
         if (VEC[i].wt == 0) #1;
         else edges(int'(VEC[i].wt));
         check(VEC[i].en, VEC[i].dom, $sformatf("R%0d vector %0d", VEC[i].req, i));
      end

      // R1: reset clears a fired time-out and a latched thermal state
      txd_pin  = 1'b0;
      otemp_in = 1'b1;
      edges(TO + SY + 2);
      check(1'b0, 1'b0, "R3 faults before reset");
      otemp_in = 1'b0;
      edges(SY + 1);
      rst_n = 1'b0;
      #1;
      check(1'b1, 1'b0, "R1 reset clears faults");
      edges(2);
      rst_n = 1'b1;
      edges(SY);
      check(1'b1, 1'b1, "R1 low pin counted afresh");
      txd_pin = 1'b1;
      edges(SY + 1);
      check(1'b1, 0, "R1 idle");

      // R6: single-cycle heat pulse while pin high latches until a rise
      otemp_in = 1'b1;
      edges(1);
      otemp_in = 1'b0;
      edges(SY + 1);
      check(1'b0, 1'b0, "R6 short pulse latched");
      edges(20);
      check(1'b0, 1'b0, "R6 held high no release");
      txd_pin = 1'b0;
      edges(3);
      txd_pin = 1'b1;
      edges(SY + 1);
      check(1'b1, 1'b0, "R6 released by rise");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule